// File: doc/BRIEF.md
# Two-Region Erase Range Walker

This block sits between a storage driver and a single-block erase engine for a flash array whose erase granularity is not uniform. The lower region is made of small blocks and the upper region, which starts immediately after it, is made of large blocks. A caller pulses `reqStart` with a byte start address and a byte length. The walker checks the range against the geometry and, if it is legal, asks the erase engine for one block erase at a time, in rising address order.

The step between two requested blocks is the block size of the region the walker is in at that moment. The step grows when the walk crosses into the upper region. The caller learns the outcome from a one-cycle `done` pulse, with a status code that stays valid until the next outcome. The code reports success, a rejected range, or the first block whose erase failed.

With the default parameters, the lower region holds 8 blocks of 16 KiB and the upper region holds 31 blocks of 128 KiB starting at 128 KiB. The device therefore spans 4 MiB.

Top module: `erase_walker`

## Requirements
- R1: The lower region covers addresses [0, CNT0·2^LOG_BLK0) in blocks of 2^LOG_BLK0 bytes. The upper region starts at CNT0·2^LOG_BLK0 and holds CNT1 blocks of 2^LOG_BLK1 bytes. A range that crosses from the lower region into the upper one is walked in small steps up to the boundary and in large steps after it.
- R2: A start address that is not a multiple of the block size of its own region makes `done` pulse with `status` = 1 (invalid) one cycle after `reqStart`, and no erase is requested.
- R3: The end address (start + length) must be a multiple of the block size of the region that holds it, where an end equal to the upper region's first address counts as upper region. Otherwise the result is `status` = 1 with no erase requested.
- R4: A start address at or above the device size, or an end address above it, gives `status` = 1 with no erase requested.
- R5: A zero length gives `done` with `status` = 0 one cycle after `reqStart`, whatever the address, and requests no erase.
- R6: A legal nonzero range produces exactly one erase request per block, covering the range in rising order. Each `eraseAddr` is the first byte of its block.
- R7: `eraseReq` stays high with a stable `eraseAddr` until the cycle in which `eraseAck` is high.
- R8: If `eraseFail` is high together with `eraseAck`, the walk stops. `done` pulses next cycle with `status` = 2 (I/O error) and no further erase is requested.
- R9: After the successful acknowledge of the last block, `done` pulses next cycle with `status` = 0 and `eraseReq` is low.
- R10: A `reqStart` pulse while a walk is in progress is ignored. The running walk's block sequence and result are unchanged.
- R11: After reset, `eraseReq` and `done` are low and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqStart | input | 1 | One-cycle pulse that launches a request |
| reqAddr | input | ADDR_W | Byte start address of the request |
| reqLen | input | ADDR_W | Byte length of the request |
| eraseReq | output | 1 | Block erase request toward the erase engine |
| eraseAddr | output | ADDR_W | First byte of the block to erase |
| eraseAck | input | 1 | Erase engine finished the current block |
| eraseFail | input | 1 | Qualifies `eraseAck`: the block erase failed |
| done | output | 1 | One-cycle pulse when a request has finished |
| status | output | 2 | Result: 0 success, 1 invalid range, 2 I/O error |

## Verification
The case hardest to reach from the ports is a walk that fails partway through after it has already crossed the region boundary. Reaching it needs a legal range that spans both regions, plus an engine that fails one chosen block. The bench sweeps every start and length on a fine grid over a shrunken geometry, so that every mix of alignment, boundary crossing and out-of-range end is covered. It then replays the full-device range once for each block index, with the engine failing that block. A start pulse is also injected in the middle of a walk, to show that it is ignored.

// File: rtl/erase_walker_pkg.sv
package erase_walker_pkg;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_INVAL = 2'd1,
    ST_IOERR = 2'd2
  } walkStatus_t;

  typedef struct packed {
    logic load;
    logic step;
  } walkStrobe_t;

endpackage

// File: rtl/erase_walker_dp.sv
module erase_walker_dp
  import erase_walker_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LOG_BLK0 = 14,
  parameter int CNT0     = 8,
  parameter int LOG_BLK1 = 17,
  parameter int CNT1     = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] reqLen,
  output logic              reqZero,
  output logic              reqLegal,
  output logic              lastBlk,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int WA = ADDR_W + 1;
  localparam logic [WA-1:0] BLK0 = WA'(1) << LOG_BLK0;
  localparam logic [WA-1:0] BLK1 = WA'(1) << LOG_BLK1;
  localparam logic [WA-1:0] HI_BASE = WA'(CNT0) << LOG_BLK0;
  localparam logic [WA-1:0] DEV_SIZE = HI_BASE + (WA'(CNT1) << LOG_BLK1);

  logic [WA-1:0] startExt, endExt, startMask, endMask;
  logic          startHi, endHi;
  logic [WA-1:0] addrQ, remQ, stepSize, nextAddr;
  logic          inHi;

  // request screening, purely from the incoming request
  always_comb begin
    startExt  = {1'b0, reqAddr};
    endExt    = startExt + {1'b0, reqLen};
    startHi   = startExt >= HI_BASE;
    endHi     = endExt >= HI_BASE;
    startMask = startHi ? BLK1 - WA'(1) : BLK0 - WA'(1);
    endMask   = endHi ? BLK1 - WA'(1) : BLK0 - WA'(1);
    reqZero   = (reqLen == '0);
    reqLegal  = (startExt < DEV_SIZE) && (endExt <= DEV_SIZE) &&
                ((startExt & startMask) == '0) && ((endExt & endMask) == '0);
  end

  // walk state
  always_comb begin
    stepSize = inHi ? BLK1 : BLK0;
    nextAddr = addrQ + stepSize;
    lastBlk  = (remQ == stepSize);
    curAddr  = addrQ[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      remQ  <= '0;
      inHi  <= 1'b0;
    end else if (strb.load) begin
      addrQ <= startExt;
      remQ  <= {1'b0, reqLen};
      inHi  <= startHi;
    end else if (strb.step) begin
      addrQ <= nextAddr;
      remQ  <= remQ - stepSize;
      if (nextAddr == HI_BASE) inHi <= 1'b1;
    end
  end

  // R1: once in the upper region a walk never drops back to small steps
  a_r1_region_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inHi) |-> $past(strb.load));

endmodule

// File: rtl/erase_walker_ctrl.sv
module erase_walker_ctrl
  import erase_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqStart,
  input  logic        reqZero,
  input  logic        reqLegal,
  input  logic        lastBlk,
  input  logic        eraseAck,
  input  logic        eraseFail,
  output walkStrobe_t strb,
  output logic        eraseReq,
  output logic        done,
  output logic [1:0]  status
);
  typedef enum logic {S_IDLE, S_WALK} walkState_t;
  walkState_t st;

  always_comb begin
    strb      = '0;
    strb.load = (st == S_IDLE) && reqStart && !reqZero && reqLegal;
    strb.step = (st == S_WALK) && eraseAck && !eraseFail && !lastBlk;
    eraseReq  = (st == S_WALK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      status <= ST_OK;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (reqStart) begin
          if (reqZero) begin
            done   <= 1'b1;
            status <= ST_OK;
          end else if (!reqLegal) begin
            done   <= 1'b1;
            status <= ST_INVAL;
          end else begin
            st <= S_WALK;
          end
        end
        S_WALK: if (eraseAck) begin
          if (eraseFail) begin
            st     <= S_IDLE;
            done   <= 1'b1;
            status <= ST_IOERR;
          end else if (lastBlk) begin
            st     <= S_IDLE;
            done   <= 1'b1;
            status <= ST_OK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r8_fail_stops: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq && eraseAck && eraseFail |=> !eraseReq && done && status == ST_IOERR);

  a_r2_inval_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done && status == ST_INVAL |-> !$past(eraseReq));

  a_r5_zero_len: assert property (@(posedge clk) disable iff (!rstN)
    reqStart && !eraseReq && reqZero |=> done && status == ST_OK && !eraseReq);

  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    reqStart && eraseReq && !eraseAck |=> eraseReq);

endmodule

// File: rtl/erase_walker.sv
module erase_walker
  import erase_walker_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LOG_BLK0 = 14,
  parameter int CNT0     = 8,
  parameter int LOG_BLK1 = 17,
  parameter int CNT1     = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStart,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] reqLen,
  output logic              eraseReq,
  output logic [ADDR_W-1:0] eraseAddr,
  input  logic              eraseAck,
  input  logic              eraseFail,
  output logic              done,
  output logic [1:0]        status
);
  localparam int WA = ADDR_W + 1;
  localparam logic [WA-1:0] HI_BASE = WA'(CNT0) << LOG_BLK0;
  localparam logic [WA-1:0] DEV_SIZE = HI_BASE + (WA'(CNT1) << LOG_BLK1);

  walkStrobe_t strb;
  logic        reqZero, reqLegal, lastBlk;

  erase_walker_dp #(
    .ADDR_W(ADDR_W), .LOG_BLK0(LOG_BLK0), .CNT0(CNT0),
    .LOG_BLK1(LOG_BLK1), .CNT1(CNT1)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddr(reqAddr), .reqLen(reqLen),
    .reqZero(reqZero), .reqLegal(reqLegal), .lastBlk(lastBlk),
    .curAddr(eraseAddr)
  );

  erase_walker_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqStart(reqStart),
    .reqZero(reqZero), .reqLegal(reqLegal), .lastBlk(lastBlk),
    .eraseAck(eraseAck), .eraseFail(eraseFail),
    .strb(strb), .eraseReq(eraseReq), .done(done), .status(status)
  );

  logic [WA-1:0] addrExt, addrMask;
  always_comb begin
    addrExt  = {1'b0, eraseAddr};
    addrMask = (addrExt >= HI_BASE) ? ((WA'(1) << LOG_BLK1) - WA'(1))
                                    : ((WA'(1) << LOG_BLK0) - WA'(1));
  end

  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq && !eraseAck |=> eraseReq && $stable(eraseAddr));

  a_r6_aligned_in_range: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |-> (addrExt < DEV_SIZE) && ((addrExt & addrMask) == '0));

endmodule

// File: tb/erase_walker_bench.sv
module erase_walker_bench;
  localparam int AW = 9;
  localparam int LB0 = 3, C0 = 4, LB1 = 5, C1 = 3;
  localparam int B0 = 1 << LB0, B1 = 1 << LB1;
  localparam int HIB = C0 * B0;
  localparam int DEV = HIB + C1 * B1;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqStart = 1'b0;
  logic [AW-1:0] reqAddr = '0, reqLen = '0;
  logic eraseReq, eraseAck = 1'b0, eraseFail = 1'b0, done;
  logic [AW-1:0] eraseAddr;
  logic [1:0] status;

  erase_walker #(.ADDR_W(AW), .LOG_BLK0(LB0), .CNT0(C0), .LOG_BLK1(LB1), .CNT1(C1)) u_erase_walker (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqAddr(reqAddr), .reqLen(reqLen),
    .eraseReq(eraseReq), .eraseAddr(eraseAddr), .eraseAck(eraseAck), .eraseFail(eraseFail),
    .done(done), .status(status));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  int expAddr [0:63];
  int expN = 0;
  int gotN = 0, misN = 0, holdBad = 0, waitCnt = 0, firstAddr = 0;
  int engDelay = 0, engFailIdx = -1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // erase engine model
  initial begin
    forever begin
      @(negedge clk);
      eraseAck = 1'b0;
      eraseFail = 1'b0;
      if (eraseReq) begin
        if (waitCnt == 0) firstAddr = int'(eraseAddr);
        if (waitCnt < engDelay) waitCnt++;
        else begin
          if (int'(eraseAddr) != firstAddr) holdBad++;
          if (gotN >= expN || expAddr[gotN] != int'(eraseAddr)) misN++;
          eraseAck = 1'b1;
          eraseFail = (gotN == engFailIdx);
          gotN++;
          waitCnt = 0;
        end
      end
    end
  end

  task automatic runReq(input int s, input int l, input int failIdx, input int dly, input bit intrude);
    int e, expSt, a, wantN, cyc;
    string tag;
    bit legal, sentIntr;
    e = s + l;
    legal = (s < DEV) && (e <= DEV) && (s % ((s >= HIB) ? B1 : B0) == 0) &&
            (e % ((e >= HIB) ? B1 : B0) == 0);
    expN = 0;
    if (l != 0 && legal) begin
      a = s;
      while (a < e) begin
        expAddr[expN] = a;
        expN++;
        a += (a < HIB) ? B0 : B1;
      end
    end
    if (l == 0) begin tag = "R5"; expSt = 0; wantN = 0; end
    else if (!legal) begin
      if (s >= DEV || e > DEV) tag = "R4";
      else if (s % ((s >= HIB) ? B1 : B0) != 0) tag = "R2";
      else tag = "R3";
      expSt = 1; wantN = 0;
    end else if (failIdx >= 0 && failIdx < expN) begin
      tag = "R8"; expSt = 2; wantN = failIdx + 1;
    end else begin
      tag = (s < HIB && e > HIB) ? "R1" : (intrude ? "R10" : "R6");
      expSt = 0; wantN = expN;
    end
    gotN = 0; misN = 0; holdBad = 0; waitCnt = 0;
    engDelay = dly; engFailIdx = failIdx;
    @(negedge clk);
    reqAddr = AW'(s); reqLen = AW'(l); reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    if (l == 0 || !legal) check(done === 1'b1, {tag, " done latency"}, int'(done), 1);
    cyc = 0; sentIntr = 1'b0;
    while (done !== 1'b1 && cyc < 600) begin
      if (intrude && !sentIntr && gotN == 1) begin
        reqAddr = AW'(4); reqLen = AW'(4); reqStart = 1'b1; sentIntr = 1'b1;
      end else reqStart = 1'b0;
      @(negedge clk);
      cyc++;
    end
    reqStart = 1'b0;
    check(done === 1'b1, {tag, " done seen"}, int'(done), 1);
    check(int'(status) == expSt, {tag, " status"}, int'(status), expSt);
    check(gotN == wantN, {tag, " block count"}, gotN, wantN);
    check(misN == 0, {tag, " block addresses (R6)"}, misN, 0);
    check(holdBad == 0, "R7 address held until ack", holdBad, 0);
    check(eraseReq === 1'b0, "R9 request low at done", int'(eraseReq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(eraseReq === 1'b0, "R11 eraseReq", int'(eraseReq), 0);
    check(done === 1'b0, "R11 done", int'(done), 0);
    check(status === 2'd0, "R11 status", int'(status), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // sweep of starts and lengths on a 4-byte grid
    for (int s = 0; s <= DEV + 8; s += 4)
      for (int l = 0; l <= DEV + 8; l += 4)
        runReq(s, l, -1, (s / 4 + l / 4) % 3, 1'b0);
    // end beyond the address space width
    runReq(0, (1 << AW) - 1, -1, 0, 1'b0);
    runReq(DEV - B1, (1 << AW) - B1, -1, 0, 1'b0);
    // failure at every block of the full device, crossing the boundary
    for (int k = 0; k < C0 + C1; k++) runReq(0, DEV, k, k % 2, 1'b0);
    runReq(HIB - B0, B0 + B1, 1, 1, 1'b0);
    // start pulse during a walk
    runReq(0, DEV, -1, 2, 1'b1);
    runReq(HIB, 2 * B1, -1, 3, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule